// File: doc/BRIEF.md
# Clock Synthesizer Lock Supervisor

This block supervises an on-chip clock synthesizer. It watches the synthesizer's lock flag and its status fault bits. When they show a problem that lasts longer than a hold-off interval, it pulses the synthesizer's active-high reset. It also gives downstream logic a qualified "clocks good" flag. All of its logic runs on a free-running reference clock, which is the synthesizer's input clock or any other clock that never stops. No synthesizer output clock is used, because those outputs stop while the synthesizer is held in reset.

A single wrapping hold-off counter does the work. While the synthesizer is healthy, the counter is held at zero, so short drops in lock are filtered out. While it is unhealthy, the counter advances by one per cycle. The synthesizer reset is driven high only while the counter sits in a short window just below its full count, and the wrap back to zero releases it. The time between pulses gives the synthesizer at least one full hold-off interval to lock. If it never locks, the pulses repeat. The lock and fault inputs pass through a parameterised synchronizer before they are used.

Top module: `clk_lock_supervisor`

## Requirements
- R1: While `rst_n` is low, `synth_rst_o` and `clocks_good_o` are both low and the hold-off counter is zero.
- R2: The counter returns to zero on any cycle where the synchronised inputs are healthy. A loss of health that clears before the reset window is reached produces no reset pulse. A later fault must again count the full interval.
- R3: Healthy means the lock input is 1 and every bit of `synth_fault_i` is 0. Any single fault bit at 1 counts as unhealthy, even while lock is 1.
- R4: Suppose the inputs turn unhealthy, starting from a healthy state with the counter at zero. `synth_rst_o` then rises on the SYNC_STAGES + 2^CNT_W − RST_WIN'th clock edge after the change. With the bench values this is edge 62.
- R5: Each reset pulse lasts exactly RST_WIN cycles (at least 4). It ends when the counter wraps to zero. Once a pulse has started it completes, even if health returns during it.
- R6: While the inputs stay unhealthy, reset pulses repeat with a period of 2^CNT_W cycles.
- R7: After power-up reset is released with lock low, `synth_rst_o` stays low for 2^CNT_W − RST_WIN − 1 edges. It rises on edge 2^CNT_W − RST_WIN.
- R8: `clocks_good_o` rises on the SYNC_STAGES + GOOD_CYC'th edge after the inputs become and stay healthy. It falls on the SYNC_STAGES + 1'th edge after health is lost. It is never high while `synth_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor |
| synth_locked_i | input | 1 | Lock flag from the clock synthesizer |
| synth_fault_i | input | STATUS_W | Status fault bits; any bit at 1 is abnormal |
| synth_rst_o | output | 1 | Active-high reset to the synthesizer |
| clocks_good_o | output | 1 | Qualified flag that the synthesizer clocks are usable |

## Verification
The hardest case to reach is health coming back during a reset pulse that has already started. The bench holds lock low until it sees the pulse rise. It then restores lock at once and checks that the pulse still runs its full length and ends only at the wrap. The glitch filter is also checked from the ports: a long but sub-threshold drop is followed by a second drop, and the bench checks that the second drop needs the full interval again. A fault bit set while lock stays high is used to drive the counter through two full wrap periods, which checks the periodic retry.

// File: rtl/lock_sup_pkg.sv
`timescale 1ns/1ps
package lock_sup_pkg;
   // position of the lock flag in the synchronised health vector
   localparam int unsigned LOCK_IDX = 0;

   // first counter value inside the reset window (full count minus window plus one)
   function automatic int unsigned win_start(input int unsigned cnt_w, input int unsigned win);
      return (32'd1 << cnt_w) - win;
   endfunction
endpackage

// File: rtl/lock_sup_sync.sv
`timescale 1ns/1ps
module lock_sup_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lock_sup_holdoff.sv
`timescale 1ns/1ps
module lock_sup_holdoff #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned RST_WIN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             healthy_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             synth_rst_o
);
   localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(lock_sup_pkg::win_start(CNT_W, RST_WIN));

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             win_q;

   // inside the window the count always advances so the pulse runs to the wrap
   always_comb begin
      if (win_q || !healthy_i) cnt_d = cnt_q + 1'b1;
      else                     cnt_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         win_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         win_q <= (cnt_d >= WIN_LO);
      end
   end

   assign cnt_o       = cnt_q;
   assign synth_rst_o = win_q;
endmodule

// File: rtl/lock_sup_good.sv
`timescale 1ns/1ps
module lock_sup_good #(
   parameter int unsigned GOOD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic healthy_i,
   input  logic synth_rst_i,
   output logic good_o
);
   generate
      if (GOOD_CYC == 0) begin : g_direct
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign good_o = healthy_i & ~synth_rst_i;
      end else begin : g_run
         localparam int unsigned GW = $clog2(GOOD_CYC + 1);
         localparam logic [GW-1:0] RUN_MAX = GW'(GOOD_CYC);
         logic [GW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         run_q <= '0;
            else if (!healthy_i || synth_rst_i) run_q <= '0;
            else if (run_q != RUN_MAX)          run_q <= run_q + 1'b1;
         end
         assign good_o = (run_q == RUN_MAX);
      end
   endgenerate
endmodule

// File: rtl/clk_lock_supervisor.sv
`timescale 1ns/1ps
module clk_lock_supervisor #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned RST_WIN     = 4,
   parameter int unsigned STATUS_W    = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GOOD_CYC    = 4
) (
   input  logic                clk_ref,
   input  logic                rst_n,
   input  logic                synth_locked_i,
   input  logic [STATUS_W-1:0] synth_fault_i,
   output logic                synth_rst_o,
   output logic                clocks_good_o
);
   localparam int unsigned HW = STATUS_W + 1;

   generate
      if (CNT_W < 3 || CNT_W > 30) begin : g_bad_cnt_w
         $error("CNT_W must lie in 3..30");
      end
      if (RST_WIN < 4 || RST_WIN > (32'd1 << (CNT_W - 1))) begin : g_bad_win
         $error("RST_WIN must be at least 4 and at most half the count range");
      end
      if (STATUS_W < 1) begin : g_bad_status
         $error("STATUS_W must be at least 1");
      end
   endgenerate

   logic [HW-1:0]    raw_vec, sync_vec;
   logic             healthy_s;
   logic [CNT_W-1:0] hold_cnt;

   assign raw_vec = {synth_fault_i, synth_locked_i};

   lock_sup_sync #(.W(HW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .d     (raw_vec),
      .q     (sync_vec)
   );

   assign healthy_s = sync_vec[lock_sup_pkg::LOCK_IDX] & ~(|sync_vec[HW-1:1]);

   lock_sup_holdoff #(.CNT_W(CNT_W), .RST_WIN(RST_WIN)) u_holdoff (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .healthy_i   (healthy_s),
      .cnt_o       (hold_cnt),
      .synth_rst_o (synth_rst_o)
   );

   lock_sup_good #(.GOOD_CYC(GOOD_CYC)) u_good (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .healthy_i   (healthy_s),
      .synth_rst_i (synth_rst_o),
      .good_o      (clocks_good_o)
   );
endmodule

// File: rtl/lock_sup_chk.sv
`timescale 1ns/1ps
module lock_sup_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             synth_rst,
   input logic             clocks_good,
   input logic [CNT_W-1:0] hold_cnt
);
   always @(posedge clk) begin
      if (!rst_n) begin
         // R1
         reset_quiet_chk: assert (!synth_rst && !clocks_good && hold_cnt == '0);
      end
   end

   // R5
   pulse_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(synth_rst) |-> ($past(synth_rst, 2) && $past(synth_rst, 3)));

   // R5
   release_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(synth_rst) |-> (hold_cnt == '0));

   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_cnt != '0) |-> (hold_cnt == CNT_W'($past(hold_cnt) + 1'b1)));

   // R8
   good_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(synth_rst && clocks_good));
endmodule

bind clk_lock_supervisor lock_sup_chk #(.CNT_W(CNT_W)) u_lock_sup_chk (
   .clk         (clk_ref),
   .rst_n       (rst_n),
   .synth_rst   (synth_rst_o),
   .clocks_good (clocks_good_o),
   .hold_cnt    (hold_cnt)
);

// File: tb/clk_lock_supervisor_tb.sv
`timescale 1ns/1ps
module clk_lock_supervisor_tb;
   localparam int unsigned CNT_W = 6;
   localparam int unsigned WIN   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       locked = 1'b0;
   logic [1:0] fault = 2'b00;
   logic       synth_rst, good;
   int         checks = 0;
   int         failures = 0;

   always #2.5 clk = ~clk;

   clk_lock_supervisor #(
      .CNT_W(CNT_W), .RST_WIN(WIN), .STATUS_W(2), .SYNC_STAGES(2), .GOOD_CYC(4)
   ) u_dut (
      .clk_ref        (clk),
      .rst_n          (rst_n),
      .synth_locked_i (locked),
      .synth_fault_i  (fault),
      .synth_rst_o    (synth_rst),
      .clocks_good_o  (good)
   );

   typedef struct packed {
      logic       lk;
      logic [1:0] flt;
      logic [7:0] waitc;
      logic       exp_rst;
      logic       exp_good;
   } vec_t;

   // good-flag timing walk from a settled healthy state (R8, R3)
   localparam vec_t VECS [9] = '{
      '{1'b0, 2'b00, 8'd2,  1'b0, 1'b1},
      '{1'b0, 2'b00, 8'd1,  1'b0, 1'b0},
      '{1'b1, 2'b00, 8'd5,  1'b0, 1'b0},
      '{1'b1, 2'b00, 8'd1,  1'b0, 1'b1},
      '{1'b1, 2'b01, 8'd3,  1'b0, 1'b0},
      '{1'b1, 2'b00, 8'd10, 1'b0, 1'b1},
      '{1'b1, 2'b11, 8'd2,  1'b0, 1'b1},
      '{1'b1, 2'b11, 8'd1,  1'b0, 1'b0},
      '{1'b1, 2'b00, 8'd10, 1'b0, 1'b1}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   initial begin
      #100000;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: reset state
      tick(3);
      chk("R1", "synth_rst in reset", synth_rst, 1'b0);
      chk("R1", "good in reset", good, 1'b0);
      rst_n = 1'b1;
      // R7: power-up with lock low
      tick(59);
      chk("R7", "rst before first pulse", synth_rst, 1'b0);
      tick(1);
      chk("R7", "first pulse rises", synth_rst, 1'b1);
      tick(3);
      chk("R5", "pulse held through window", synth_rst, 1'b1);
      tick(1);
      chk("R5", "pulse released at wrap", synth_rst, 1'b0);
      locked = 1'b1;
      tick(10);
      chk("R8", "good after lock", good, 1'b1);
      chk("R2", "no reset while healthy", synth_rst, 1'b0);

      // table walk
      for (int i = 0; i < 9; i++) begin
         locked = VECS[i].lk;
         fault  = VECS[i].flt;
         tick(int'(VECS[i].waitc));
         chk("R8", $sformatf("vec %0d good", i), good, VECS[i].exp_good);
         chk("R3", $sformatf("vec %0d rst", i), synth_rst, VECS[i].exp_rst);
      end

      // R2: sub-threshold drop is filtered, counter restarts
      locked = 1'b0;
      tick(50);
      chk("R2", "long glitch no reset", synth_rst, 1'b0);
      locked = 1'b1;
      tick(10);
      chk("R2", "rst low after recovery", synth_rst, 1'b0);
      locked = 1'b0;
      tick(61);
      chk("R2", "second drop needs full interval", synth_rst, 1'b0);
      tick(1);
      chk("R4", "pulse on edge 62", synth_rst, 1'b1);
      // R5: health returns mid-pulse, pulse still completes
      locked = 1'b1;
      tick(3);
      chk("R5", "pulse completes despite lock", synth_rst, 1'b1);
      chk("R8", "good low during pulse", good, 1'b0);
      tick(1);
      chk("R5", "pulse ends after RST_WIN", synth_rst, 1'b0);
      tick(10);
      chk("R8", "good after pulse", good, 1'b1);

      // R3: fault bit with lock high, then R6 periodic retry
      fault = 2'b10;
      tick(61);
      chk("R3", "fault bit rst not yet", synth_rst, 1'b0);
      tick(1);
      chk("R3", "fault bit triggers pulse", synth_rst, 1'b1);
      tick(4);
      chk("R5", "fault pulse released", synth_rst, 1'b0);
      tick(59);
      chk("R6", "before retry pulse", synth_rst, 1'b0);
      tick(1);
      chk("R6", "retry pulse one period later", synth_rst, 1'b1);
      fault = 2'b00;
      tick(12);
      chk("R6", "recovered no reset", synth_rst, 1'b0);
      chk("R8", "recovered good", good, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule